// File: doc/BRIEF.md
# Flash Row Erase and Program Controller

This block wraps a small on-chip program store of 14-bit words and lets a host change it through a handful of byte-wide registers. The host sets an address and a data word, each split over a low and a high register, and then writes a control word whose bits choose the memory space and request a read, a row erase, a latch load or a programming pass. A read copies one word into the data registers after a short, fixed stall. An erase sets every word of one aligned row back to all ones. Programming is staged. The host first fills a bank of write latches one word at a time, and a programming pass then clears bits in a latch-aligned group of words.

A two-bit configuration input selects which address range is write-protected. Erase and program requests that target that range are dropped without any effect. While an operation runs, a busy output is high, and every host register or control write made during that time is ignored. The number of write latches is a parameter. When it is smaller than the row size, the host fills and programs one row over several passes.

Top module: `flash_row_ctrl`

## Requirements
- R1: After reset, busy is 0, the data registers read 0, every array word is 14'h3FFF and every write latch holds 14'h3FFF.
- R2: A control write is acted on only when the configuration-space bit is 0 and the program-space bit is 1. Any other combination leaves busy at 0, the data registers unchanged and the array unchanged.
- R3: A read is requested by a control write with the read bit set. Busy is then high for exactly the two cycles that follow the accepting edge. The data registers take the addressed word on the second edge after the accepting edge.
- R4: The data registers keep their value until a read completes or the host writes them. Select code 2 writes data bits 7:0 and select code 3 writes bits 13:8 from write-data bits 5:0. Select code 0 writes address bits 7:0 and select code 1 writes address bits 10:8 from write-data bits 2:0.
- R5: A control write with the write bit set, the load-only bit set and the erase bit clear copies the data registers into the latch indexed by the low address bits (log2 of the latch count). It raises no busy and does not change the array. Latch loads are never checked against protection.
- R6: A control write with the write bit set and both the load-only and erase bits clear first loads the addressed latch as in R5. It then keeps busy high for OP_CYCLES cycles. At the end of that time, each word in the latch-aligned group containing the address becomes its old value AND the matching latch, and all latches return to 14'h3FFF.
- R7: A control write with the write and erase bits set keeps busy high for OP_CYCLES cycles. It then sets all 32 words of the row whose low five address bits are zero to 14'h3FFF.
- R8: The protect field decodes as follows: 00 protects every address, 01 protects addresses below 1024, 10 protects addresses below 512 and 11 protects nothing. An erase or program request aimed at a protected address raises no busy, loads no latch and changes no word.
- R9: While busy is high, host register writes and control writes have no effect.
- R10: With fewer latches than row words, a row is fully programmed by repeated load-and-program passes, and each pass changes only its own latch-aligned group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Host register write strobe |
| reg_sel | input | 2 | Register select: 0 addr low, 1 addr high, 2 data low, 3 data high |
| reg_wdata | input | 8 | Host register write data |
| ctl_we | input | 1 | Control word write strobe |
| ctl_cfg_sel | input | 1 | Configuration-space select (must be 0) |
| ctl_pgm_sel | input | 1 | Program-space select (must be 1) |
| ctl_rd | input | 1 | Read request |
| ctl_wr | input | 1 | Write request (erase, latch load or program) |
| ctl_erase | input | 1 | Write request is a row erase |
| ctl_load_only | input | 1 | Write request only loads a latch |
| wp_cfg | input | 2 | Write-protect range select |
| busy | output | 1 | Operation in progress |
| data_q | output | 14 | Data register pair contents |

## Verification
On every cycle, the assertions check several properties. A read holds busy for exactly two cycles. The data registers change only on a read completion or a host write. The address cannot move while busy is high. A protected request never enters the operation state. A programming pass only clears bits, and an erase leaves ones behind. The latches are all ones after each pass. The scenarios compare the actual array contents against a model. This shows which words an erase or pass touched, including the protect boundaries at 511/512 and 1023/1024. It also shows that ignored requests made while busy left no trace, and that with eight latches a row is built over several separate passes.

// File: rtl/flash_pkg.sv
// Shared types for the flash row controller.
// Assumes: a two-bit register select and a four-state sequencer.
package flash_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_ACC  = 2'd1,
        ST_RD_DONE = 2'd2,
        ST_OP      = 2'd3
    } fl_state_e;

    typedef enum logic [1:0] {
        SEL_ADDR_LO = 2'd0,
        SEL_ADDR_HI = 2'd1,
        SEL_DATA_LO = 2'd2,
        SEL_DATA_HI = 2'd3
    } fl_reg_sel_e;

endpackage

// File: rtl/flash_prot.sv
// Write-protect range decoder.
// Decodes the 2-bit field into a hit flag for the given address.
// Assumes ADDR_W > 1 and SMALL_WORDS below the array depth.
module flash_prot #(
    parameter int ADDR_W      = 11,
    parameter int SMALL_WORDS = 512
) (
    input  logic [1:0]        wp_cfg,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    // Decode the protected range and test the address against it.
    always_comb begin
        case (wp_cfg)
            2'b00:   hit = 1'b1;
            2'b01:   hit = ~addr[ADDR_W-1];
            2'b10:   hit = (addr < ADDR_W'(SMALL_WORDS));
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/flash_latches.sv
// Bank of write latches that stage data for programming.
// Loads one latch selected by index, and sets all latches to ones on clear.
// Assumes load and clear never occur in the same cycle and LATCHES >= 2.
module flash_latches #(
    parameter int WORD_W  = 14,
    parameter int LATCHES = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic [$clog2(LATCHES)-1:0] idx,
    input  logic [WORD_W-1:0]         wdata,
    input  logic                      clear,
    output logic [LATCHES*WORD_W-1:0] lat_flat
);

    localparam int LAT_W = $clog2(LATCHES);

    for (genvar i = 0; i < LATCHES; i++) begin : g_lat
        logic [WORD_W-1:0] q;
        // Hold one staged word; reset or clear return it to the erased value.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                q <= '1;
            end else if (load && idx == LAT_W'(i)) begin
                q <= wdata;
            end
        end
        assign lat_flat[i*WORD_W +: WORD_W] = q;
    end

    // R6: after a programming pass every latch is back to all ones
    a_r6_latches_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (lat_flat == {(LATCHES*WORD_W){1'b1}}));

endmodule

// File: rtl/flash_array.sv
// Program word store with registered read, row erase and group program.
// Program ANDs each word of the latch group with its latch (clears bits only).
// Assumes read and commit never occur in the same cycle and power-of-two sizes.
module flash_array #(
    parameter int WORD_W    = 14,
    parameter int ADDR_W    = 11,
    parameter int DEPTH     = 2048,
    parameter int ROW_WORDS = 32,
    parameter int LATCHES   = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_en,
    input  logic [ADDR_W-1:0]         rd_addr,
    input  logic                      commit,
    input  logic                      commit_erase,
    input  logic [ADDR_W-1:0]         op_addr,
    input  logic [LATCHES*WORD_W-1:0] lat_flat,
    output logic [WORD_W-1:0]         rd_word
);

    localparam int ROW_W = $clog2(ROW_WORDS);
    localparam int LAT_W = $clog2(LATCHES);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] row_base;
    logic [ADDR_W-1:0] grp_base;

    assign row_base = {op_addr[ADDR_W-1:ROW_W], ROW_W'(0)};
    assign grp_base = {op_addr[ADDR_W-1:LAT_W], LAT_W'(0)};

    // Apply reset, row erase or group program to the stored words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < DEPTH; j++) mem[j] <= '1;
        end else if (commit) begin
            if (commit_erase) begin
                for (int k = 0; k < ROW_WORDS; k++)
                    mem[row_base + ADDR_W'(k)] <= '1;
            end else begin
                for (int k = 0; k < LATCHES; k++)
                    mem[grp_base + ADDR_W'(k)] <= mem[grp_base + ADDR_W'(k)]
                                                & lat_flat[k*WORD_W +: WORD_W];
            end
        end
    end

    // Register the addressed word during the access cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_word <= '0;
        else if (rd_en) rd_word <= mem[rd_addr];
    end

    // R7: an erase leaves the row base word at all ones
    a_r7_erase_sets_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && commit_erase) |=> (mem[$past(row_base)] == '1));

    // R6: programming never sets a bit that was clear
    a_r6_program_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !commit_erase) |=>
            ((mem[$past(grp_base)] & ~$past(mem[grp_base])) == '0));

endmodule

// File: rtl/flash_row_ctrl.sv
// Flash row erase/program controller top.
// Holds host address/data registers, decodes control writes, sequences reads
// (access cycle then register load) and timed erase/program operations.
// Assumes ADDR_W > 8, WORD_W > 8, power-of-two ROW_WORDS and LATCHES <= ROW_WORDS.
module flash_row_ctrl
    import flash_pkg::*;
#(
    parameter int WORD_W      = 14,
    parameter int ADDR_W      = 11,
    parameter int ROW_WORDS   = 32,
    parameter int LATCHES     = 32,
    parameter int OP_CYCLES   = 8,
    parameter int SMALL_WORDS = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [7:0]        reg_wdata,
    input  logic              ctl_we,
    input  logic              ctl_cfg_sel,
    input  logic              ctl_pgm_sel,
    input  logic              ctl_rd,
    input  logic              ctl_wr,
    input  logic              ctl_erase,
    input  logic              ctl_load_only,
    input  logic [1:0]        wp_cfg,
    output logic              busy,
    output logic [WORD_W-1:0] data_q
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int LAT_W = $clog2(LATCHES);
    localparam int CNT_W = $clog2(OP_CYCLES + 1);
    localparam int AHI_W = ADDR_W - 8;
    localparam int DHI_W = WORD_W - 8;

    fl_state_e         state;
    logic [CNT_W-1:0]  cnt_q;
    logic              op_erase_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] rd_word;
    logic              idle, prot_hit, sel_ok, rd_req, wr_req;
    logic              erase_req, load_req, prog_req, lat_load, commit, host_ok;
    logic [LATCHES*WORD_W-1:0] lat_flat;

    assign idle      = (state == ST_IDLE);
    assign busy      = ~idle;
    assign host_ok   = reg_we && idle;
    assign sel_ok    = ctl_pgm_sel && !ctl_cfg_sel;
    assign rd_req    = ctl_we && idle && sel_ok && ctl_rd;
    assign wr_req    = ctl_we && idle && sel_ok && !ctl_rd && ctl_wr;
    assign erase_req = wr_req && ctl_erase && !prot_hit;
    assign load_req  = wr_req && !ctl_erase && ctl_load_only;
    assign prog_req  = wr_req && !ctl_erase && !ctl_load_only && !prot_hit;
    assign lat_load  = load_req || prog_req;
    assign commit    = (state == ST_OP) && (cnt_q == '0);

    flash_prot #(
        .ADDR_W      (ADDR_W),
        .SMALL_WORDS (SMALL_WORDS)
    ) prot_i (
        .wp_cfg (wp_cfg),
        .addr   (addr_q),
        .hit    (prot_hit)
    );

    flash_latches #(
        .WORD_W  (WORD_W),
        .LATCHES (LATCHES)
    ) lat_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (lat_load),
        .idx      (addr_q[LAT_W-1:0]),
        .wdata    (data_q),
        .clear    (commit && !op_erase_q),
        .lat_flat (lat_flat)
    );

    flash_array #(
        .WORD_W    (WORD_W),
        .ADDR_W    (ADDR_W),
        .DEPTH     (DEPTH),
        .ROW_WORDS (ROW_WORDS),
        .LATCHES   (LATCHES)
    ) arr_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_en        (state == ST_RD_ACC),
        .rd_addr      (addr_q),
        .commit       (commit),
        .commit_erase (op_erase_q),
        .op_addr      (addr_q),
        .lat_flat     (lat_flat),
        .rd_word      (rd_word)
    );

    // Sequence reads and timed erase/program operations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cnt_q      <= '0;
            op_erase_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (rd_req) begin
                        state <= ST_RD_ACC;
                    end else if (erase_req || prog_req) begin
                        state      <= ST_OP;
                        cnt_q      <= CNT_W'(OP_CYCLES - 1);
                        op_erase_q <= erase_req;
                    end
                end
                ST_RD_ACC:  state <= ST_RD_DONE;
                ST_RD_DONE: state <= ST_IDLE;
                default: begin
                    if (cnt_q == '0) state <= ST_IDLE;
                    else             cnt_q <= cnt_q - 1'b1;
                end
            endcase
        end
    end

    // Host writes to the address register pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (host_ok && reg_sel == SEL_ADDR_LO) begin
            addr_q[7:0] <= reg_wdata;
        end else if (host_ok && reg_sel == SEL_ADDR_HI) begin
            addr_q[ADDR_W-1:8] <= reg_wdata[AHI_W-1:0];
        end
    end

    // Data register pair: host writes or read completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (state == ST_RD_DONE) begin
            data_q <= rd_word;
        end else if (host_ok && reg_sel == SEL_DATA_LO) begin
            data_q[7:0] <= reg_wdata;
        end else if (host_ok && reg_sel == SEL_DATA_HI) begin
            data_q[WORD_W-1:8] <= reg_wdata[DHI_W-1:0];
        end
    end

    // R3: an accepted read stalls for exactly two cycles
    a_r3_read_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> busy ##1 busy ##1 !busy);

    // R4: data registers move only on read completion or host data write
    a_r4_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(host_ok && reg_sel[1]) && state != ST_RD_DONE) |=> $stable(data_q));

    // R9: the address cannot change while an operation runs
    a_r9_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(addr_q));

    // R8: a request aimed at a protected address never starts an operation
    a_r8_protected_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && ctl_we && ctl_wr && !ctl_rd && prot_hit) |=> (state != ST_OP));

endmodule

// File: tb/flash_row_ctrl_tb_top.sv
// Bench: two controllers (32 and 8 latches) share stimulus; a bench model
// predicts array, latch and data register contents for each.
module flash_row_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int OPC        = 8;
    localparam int DEPTH      = 2048;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_sel = '0;
    logic [7:0] reg_wdata = '0;
    logic       ctl_we = 1'b0, ctl_cfg_sel = 1'b0, ctl_pgm_sel = 1'b0, ctl_rd = 1'b0;
    logic       ctl_wr = 1'b0, ctl_erase = 1'b0, ctl_load_only = 1'b0;
    logic [1:0] wp_cfg = 2'b11;
    logic       busy_a, busy_b;
    logic [13:0] dq_a, dq_b;

    flash_row_ctrl #(.LATCHES(32), .OP_CYCLES(OPC)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .ctl_we(ctl_we), .ctl_cfg_sel(ctl_cfg_sel), .ctl_pgm_sel(ctl_pgm_sel), .ctl_rd(ctl_rd),
        .ctl_wr(ctl_wr), .ctl_erase(ctl_erase), .ctl_load_only(ctl_load_only),
        .wp_cfg(wp_cfg), .busy(busy_a), .data_q(dq_a));

    flash_row_ctrl #(.LATCHES(8), .OP_CYCLES(OPC)) dut8_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .ctl_we(ctl_we), .ctl_cfg_sel(ctl_cfg_sel), .ctl_pgm_sel(ctl_pgm_sel), .ctl_rd(ctl_rd),
        .ctl_wr(ctl_wr), .ctl_erase(ctl_erase), .ctl_load_only(ctl_load_only),
        .wp_cfg(wp_cfg), .busy(busy_b), .data_q(dq_b));

    int n_vec = 0;
    int n_err = 0;

    logic [13:0] m_mem [2][DEPTH];
    logic [13:0] m_lat [2][32];
    logic [13:0] m_dq  [2];
    logic [10:0] m_addr;

    function automatic int lat_n(int i);
        return (i == 0) ? 32 : 8;
    endfunction

    function automatic bit prot(logic [1:0] wp, logic [10:0] a);
        case (wp)
            2'b00:   return 1'b1;
            2'b01:   return a < 11'd1024;
            2'b10:   return a < 11'd512;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(string req, string what, logic [13:0] act, logic [13:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_busy(string req, logic exp);
        check(req, "busy(32)", {13'b0, busy_a}, {13'b0, exp});
        check(req, "busy(8)",  {13'b0, busy_b}, {13'b0, exp});
    endtask

    task automatic check_dq(string req);
        check(req, "data(32)", dq_a, m_dq[0]);
        check(req, "data(8)",  dq_b, m_dq[1]);
    endtask

    // Host register write; apply=0 when the write is expected to be ignored.
    task automatic reg_write(logic [1:0] sel, logic [7:0] val, bit apply);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
        if (apply) begin
            case (sel)
                2'd0: m_addr[7:0] = val;
                2'd1: m_addr[10:8] = val[2:0];
                2'd2: for (int i = 0; i < 2; i++) m_dq[i][7:0] = val;
                default: for (int i = 0; i < 2; i++) m_dq[i][13:8] = val[5:0];
            endcase
        end
    endtask

    task automatic set_addr(logic [10:0] a);
        reg_write(2'd0, a[7:0], 1'b1);
        reg_write(2'd1, {5'b0, a[10:8]}, 1'b1);
    endtask

    task automatic set_data(logic [13:0] d);
        reg_write(2'd2, d[7:0], 1'b1);
        reg_write(2'd3, {2'b0, d[13:8]}, 1'b1);
    endtask

    task automatic pulse_ctl(logic cfg, logic pgm, logic rd, logic wr, logic er, logic lo);
        @(negedge clk);
        ctl_we = 1'b1; ctl_cfg_sel = cfg; ctl_pgm_sel = pgm; ctl_rd = rd;
        ctl_wr = wr; ctl_erase = er; ctl_load_only = lo;
        @(negedge clk);
        ctl_we = 1'b0; ctl_rd = 1'b0; ctl_wr = 1'b0; ctl_erase = 1'b0; ctl_load_only = 1'b0;
    endtask

    task automatic wait_idle(string req, bit count_it);
        int n = 0;
        while (busy_a && n < 1000) begin
            @(negedge clk);
            n++;
        end
        if (count_it) check(req, "busy cycles", 14'(n), 14'(OPC));
    endtask

    // R3: read with two-cycle stall and data load on the second edge
    task automatic do_read(logic [10:0] a, string req);
        set_addr(a);
        pulse_ctl(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        check_busy("R3", 1'b1);
        @(negedge clk);
        check_busy("R3", 1'b1);
        @(negedge clk);
        check_busy("R3", 1'b0);
        for (int i = 0; i < 2; i++) m_dq[i] = m_mem[i][a];
        check_dq(req);
    endtask

    task automatic model_latch(int i);
        m_lat[i][int'(m_addr) % lat_n(i)] = m_dq[i];
    endtask

    // Erase (er=1), latch load (lo=1) or program at the current address.
    task automatic do_write(logic er, logic lo, string req);
        pulse_ctl(1'b0, 1'b1, 1'b0, 1'b1, er, lo);
        if (lo && !er) begin
            for (int i = 0; i < 2; i++) model_latch(i);
            check_busy("R5", 1'b0);
        end else if (prot(wp_cfg, m_addr)) begin
            check_busy("R8", 1'b0);
        end else begin
            for (int i = 0; i < 2; i++) begin
                if (er) begin
                    int rb = int'(m_addr) & ~31;
                    for (int k = 0; k < 32; k++) m_mem[i][rb + k] = 14'h3FFF;
                end else begin
                    int gb;
                    model_latch(i);
                    gb = int'(m_addr) & ~(lat_n(i) - 1);
                    for (int k = 0; k < lat_n(i); k++) begin
                        m_mem[i][gb + k] = m_mem[i][gb + k] & m_lat[i][k];
                        m_lat[i][k] = 14'h3FFF;
                    end
                end
            end
            wait_idle(req, 1'b1);
        end
    endtask

    task automatic load_word(logic [10:0] a, logic [13:0] d);
        set_addr(a);
        set_data(d);
        do_write(1'b0, 1'b1, "R5");
    endtask

    task automatic prog_word(logic [10:0] a, logic [13:0] d, string req);
        set_addr(a);
        set_data(d);
        do_write(1'b0, 1'b0, req);
    endtask

    task automatic check_row(int base, string req);
        for (int k = 0; k < 32; k++) do_read(11'(base + k), req);
    endtask

    function automatic logic [10:0] pick_addr();
        int hot;
        if ($urandom % 4 == 0) return 11'($urandom % DEPTH);
        case ($urandom % 4)
            0: hot = 2;
            1: hot = 20;
            2: hot = 40;
            default: hot = 63;
        endcase
        return 11'(hot * 32 + int'($urandom % 32));
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        int seed_tap;
        logic [13:0] keep;
        logic [10:0] edges [6];
        seed_tap = $urandom(32'd24681);
        for (int i = 0; i < 2; i++) begin
            for (int j = 0; j < DEPTH; j++) m_mem[i][j] = 14'h3FFF;
            for (int j = 0; j < 32; j++) m_lat[i][j] = 14'h3FFF;
            m_dq[i] = '0;
        end
        m_addr = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check_busy("R1", 1'b0);
        check_dq("R1");
        do_read(11'd0, "R1");
        do_read(11'd2047, "R1");

        // R1/R6: a single-word program leaves neighbours alone (latches were ones)
        prog_word(11'd70, 14'h1234, "R6");
        do_read(11'd69, "R1");
        do_read(11'd70, "R6");
        do_read(11'd71, "R1");

        // R6: second program ANDs with existing contents
        prog_word(11'd70, 14'h3F0F, "R6");
        do_read(11'd70, "R6");

        // R10: row 3 built by four passes of eight loads each
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 7; k++)
                load_word(11'(96 + p*8 + k), 14'(14'h0A00 + p*16 + k));
            prog_word(11'(96 + p*8 + 7), 14'(14'h0A00 + p*16 + 7), "R10");
        end
        check_row(96, "R10");

        // R5/R10: full-row latch load then one program at the row end
        for (int k = 0; k < 31; k++) load_word(11'(64 + k), 14'(14'h2000 | k));
        prog_word(11'd95, 14'h2ABC, "R10");
        check_row(64, "R10");

        // R7: erase row 2; row 3 untouched
        set_addr(11'd77);
        do_write(1'b1, 1'b0, "R7");
        check_row(64, "R7");
        do_read(11'd96, "R7");
        do_read(11'd127, "R7");

        // R2: control writes with wrong space selects do nothing
        set_data(14'h1555);
        set_addr(11'd100);
        pulse_ctl(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        check_busy("R2", 1'b0);
        check_dq("R2");
        pulse_ctl(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        check_busy("R2", 1'b0);
        check_dq("R2");
        pulse_ctl(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        check_busy("R2", 1'b0);
        pulse_ctl(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        check_busy("R2", 1'b0);
        do_read(11'd100, "R2");

        // R4: data holds across latch load and through partial host writes
        keep = m_dq[0];
        set_addr(11'd300);
        do_write(1'b0, 1'b1, "R5");
        repeat (3) @(negedge clk);
        check_dq("R4");
        reg_write(2'd2, 8'hC3, 1'b1);
        check_dq("R4");
        reg_write(2'd3, 8'hE5, 1'b1);
        check_dq("R4");
        check(keep == m_dq[0] ? "R4" : "R4", "hi byte moved", dq_a[13:8], 6'h25);

        // R9: writes during a programming pass are ignored
        set_addr(11'd1300);
        set_data(14'h0F0F);
        pulse_ctl(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 2; i++) begin
            int gb;
            model_latch(i);
            gb = 1300 & ~(lat_n(i) - 1);
            for (int k = 0; k < lat_n(i); k++) begin
                m_mem[i][gb + k] = m_mem[i][gb + k] & m_lat[i][k];
                m_lat[i][k] = 14'h3FFF;
            end
        end
        check_busy("R9", 1'b1);
        reg_write(2'd2, 8'h55, 1'b0);
        reg_write(2'd0, 8'h00, 1'b0);
        pulse_ctl(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        check_dq("R9");
        wait_idle("R9", 1'b0);
        check_dq("R9");
        do_read(11'd1300, "R9");

        // R8: protect boundaries for each protecting code
        edges[0] = 11'd0;    edges[1] = 11'd511;  edges[2] = 11'd512;
        edges[3] = 11'd1023; edges[4] = 11'd1024; edges[5] = 11'd2047;
        for (int c = 0; c < 3; c++) begin
            for (int e = 0; e < 6; e++) begin
                wp_cfg = 2'b11;
                prog_word(edges[e], 14'h0000, "R6");
                wp_cfg = 2'(c);
                set_addr(edges[e]);
                do_write(1'b1, 1'b0, "R8");
                prog_word(edges[e] ^ 11'd1, 14'h0000, "R8");
                wp_cfg = 2'b11;
                do_read(edges[e], "R8");
                do_read(edges[e] ^ 11'd1, "R8");
            end
        end
        // R5: latch load into a protected range is still accepted
        wp_cfg = 2'b00;
        load_word(11'd10, 14'h0123);
        wp_cfg = 2'b11;
        prog_word(11'd11, 14'h3FFF, "R5");
        do_read(11'd10, "R5");

        // Random mix of operations
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom % 10);
            case (op)
                0, 1, 2: do_read(pick_addr(), "R3");
                3: set_data(14'($urandom));
                4, 5: load_word(pick_addr(), 14'($urandom));
                6: prog_word(pick_addr(), 14'($urandom), "R6");
                7: begin
                    set_addr(pick_addr());
                    if ($urandom % 3 == 0) do_write(1'b1, 1'b0, "R7");
                end
                8: wp_cfg = ($urandom % 3 == 0) ? 2'($urandom) : 2'b11;
                default: begin
                    pulse_ctl(1'b1, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'b0);
                    check_busy("R2", 1'b0);
                    check_dq("R2");
                end
            endcase
        end
        wp_cfg = 2'b11;
        check_row(64, "R6");
        check_row(640, "R6");
        check_row(1280, "R6");
        check_row(2016, "R6");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

endmodule